// File: doc/BRIEF.md
# Packed Integer Add and Word Permute Unit

This unit is one execution slot for 64-bit packed-integer instructions. It treats each 64-bit operand as a set of lanes. It can add four 16-bit lanes or two 32-bit lanes with wrap-around. It can also add four 16-bit lanes with signed saturation. The last operation rearranges the 16-bit words of the second operand under the control of an 8-bit immediate.

The operands, the operation code and the immediate are presented together with a qualifier pulse. The result appears from a register on the following clock, together with a valid flag. When no operation is issued, the result register keeps its last value. No condition flags of any kind are produced.

The operation code is 2 bits wide:

| Code | Operation |
|---|---|
| 0 | Four-lane 16-bit wrap-around add |
| 1 | Two-lane 32-bit wrap-around add |
| 2 | Four-lane 16-bit signed saturating add |
| 3 | Word permute of `src_b` |

Top module: `simd_pack_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge. `result` changes only on an edge at which `in_valid` is 1. On any other edge it holds its value, whatever the other inputs do.
- R3: With op code 0, each 16-bit lane k of `result` (bits 16k+15 down to 16k) is the sum of the matching lanes of `src_a` and `src_b`, taken modulo 2^16. No carry passes into the next lane.
- R4: With op code 1, each 32-bit half of `result` is the sum of the matching halves of the operands, taken modulo 2^32. A carry out of bit 15 reaches bit 16. No carry passes from bit 31 into bit 32.
- R5: With op code 2, when a lane's true signed sum lies within -32768 to 32767, that lane of the result is the sum itself.
- R6: With op code 2, when both lane operands are non-negative and their signed sum exceeds 32767, the lane result is 0x7FFF.
- R7: With op code 2, when both lane operands are negative and their signed sum is below -32768, the lane result is 0x8000.
- R8: With op code 3, result word i (bits 16i+15 down to 16i) is word j of `src_b`, where j is the 2-bit value `imm` bits 2i+1 down to 2i. In this operation `src_a` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the operands and starts an operation |
| op | input | 2 | Operation code: 0 word add, 1 doubleword add, 2 saturating word add, 3 word permute |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand, and the source of the permute |
| imm | input | 8 | Permute control, two bits per output word |
| out_valid | output | 1 | High for one cycle per issued operation |
| result | output | 64 | Registered packed result |

## Verification
On every cycle, the bound assertions check the valid timing and the holding of the result. For each lane they also check the wrap-around word sum, the clamp direction in saturating mode and the word each permute field selects. Some behaviours can only be shown by the bench's scenarios. These are the carry that crosses between words in the doubleword add, the exact clamp values at each saturation boundary, and the fact that the first operand has no effect on a permute. The bench shows them with sweeps over boundary lane values and over all 256 permute immediates.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADDW  = 2'd0,
    OP_ADDD  = 2'd1,
    OP_ADDSW = 2'd2,
    OP_SHUFW = 2'd3
  } simd_op_e;
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int LANE_W  = 16,
  parameter int N_LANES = 4
) (
  input  logic [LANE_W*N_LANES-1:0] a,
  input  logic [LANE_W*N_LANES-1:0] b,
  input  logic                      pair_en,
  input  logic                      sat_en,
  output logic [LANE_W*N_LANES-1:0] sum
);
  localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [N_LANES-1:0] carry;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, raw;
    logic [LANE_W:0]   wide;
    logic              cin, ovf;

    assign a_l = a[g*LANE_W +: LANE_W];
    assign b_l = b[g*LANE_W +: LANE_W];

    // Odd lanes take the carry of the lane below only in paired (32-bit) mode
    if (g % 2 == 1) begin : g_link
      assign cin = pair_en & carry[g-1];
    end else begin : g_nolink
      assign cin = 1'b0;
    end

    assign wide     = {1'b0, a_l} + {1'b0, b_l} + {{LANE_W{1'b0}}, cin};
    assign raw      = wide[LANE_W-1:0];
    assign carry[g] = wide[LANE_W];
    // Signed overflow: operands agree in sign, result disagrees
    assign ovf      = (a_l[LANE_W-1] == b_l[LANE_W-1]) &&
                      (raw[LANE_W-1] != a_l[LANE_W-1]);

    always_comb begin
      if (sat_en && ovf) begin
        sum[g*LANE_W +: LANE_W] = a_l[LANE_W-1] ? NEG_MIN : POS_MAX;
      end else begin
        sum[g*LANE_W +: LANE_W] = raw;
      end
    end
  end
endmodule

// File: rtl/simd_word_shuffle.sv
module simd_word_shuffle #(
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 4
) (
  input  logic [WORD_W*N_WORDS-1:0]          src,
  input  logic [N_WORDS*$clog2(N_WORDS)-1:0] ctrl,
  output logic [WORD_W*N_WORDS-1:0]          dst
);
  localparam int SEL_W = $clog2(N_WORDS);

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [SEL_W-1:0] sel;
    assign sel = ctrl[g*SEL_W +: SEL_W];
    assign dst[g*WORD_W +: WORD_W] = src[sel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/simd_pack_alu.sv
module simd_pack_alu
  import simd_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int N_LANES = 4,
  parameter int DATA_W  = LANE_W * N_LANES,
  parameter int IMM_W   = N_LANES * $clog2(N_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  simd_op_e          op_e;
  logic              pair_en, sat_en;
  logic [DATA_W-1:0] add_res, shuf_res, result_d;
  logic              valid_q;
  logic [DATA_W-1:0] result_q;

  assign op_e    = simd_op_e'(op);
  assign pair_en = (op_e == OP_ADDD);
  assign sat_en  = (op_e == OP_ADDSW);

  simd_lane_adder #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_add (
    .a       (src_a),
    .b       (src_b),
    .pair_en (pair_en),
    .sat_en  (sat_en),
    .sum     (add_res)
  );

  simd_word_shuffle #(.WORD_W(LANE_W), .N_WORDS(N_LANES)) u_shuf (
    .src  (src_b),
    .ctrl (imm),
    .dst  (shuf_res)
  );

  always_comb begin
    result_d = result_q;
    if (in_valid) begin
      result_d = (op_e == OP_SHUFW) ? shuf_res : add_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= in_valid;
      result_q <= result_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/simd_pack_alu_chk.sv
module simd_pack_alu_chk #(
  parameter int LANE_W  = 16,
  parameter int N_LANES = 4,
  parameter int DATA_W  = LANE_W * N_LANES,
  parameter int IMM_W   = N_LANES * $clog2(N_LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [IMM_W-1:0]  imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int SEL_W = $clog2(N_LANES);

  logic              seen_q, vld_q;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] a_q, b_q, res_q;
  logic [IMM_W-1:0]  imm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      res_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      vld_q  <= in_valid;
      op_q   <= op;
      a_q    <= src_a;
      b_q    <= src_b;
      imm_q  <= imm;
      res_q  <= result;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (out_valid == vld_q));

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !vld_q) |-> (result == res_q));

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    // R3
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && vld_q && op_q == 2'd0) |->
      (result[g*LANE_W +: LANE_W] ==
       LANE_W'(a_q[g*LANE_W +: LANE_W] + b_q[g*LANE_W +: LANE_W])));

    // R6
    sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && vld_q && op_q == 2'd2 &&
       !a_q[g*LANE_W+LANE_W-1] && !b_q[g*LANE_W+LANE_W-1]) |->
      !result[g*LANE_W+LANE_W-1]);

    // R7
    sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && vld_q && op_q == 2'd2 &&
       a_q[g*LANE_W+LANE_W-1] && b_q[g*LANE_W+LANE_W-1]) |->
      result[g*LANE_W+LANE_W-1]);

    // R8
    shuffle_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && vld_q && op_q == 2'd3) |->
      (result[g*LANE_W +: LANE_W] ==
       b_q[imm_q[g*SEL_W +: SEL_W]*LANE_W +: LANE_W]));
  end
endmodule

bind simd_pack_alu simd_pack_alu_chk u_chk (.*);

// File: tb/simd_pack_alu_test.sv
module simd_pack_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [63:0] src_a, src_b;
  logic [7:0]  imm;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  simd_pack_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                       16'hFFFF, 16'h1234, 16'h8001, 16'hFFFE};

  function automatic logic [63:0] exp_addw(logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) r[k*16 +: 16] = a[k*16 +: 16] + b[k*16 +: 16];
    return r;
  endfunction

  function automatic logic [63:0] exp_addd(logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 2; k++) r[k*32 +: 32] = a[k*32 +: 32] + b[k*32 +: 32];
    return r;
  endfunction

  function automatic logic [63:0] exp_addsw(logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      int s;
      s = int'($signed(a[k*16 +: 16])) + int'($signed(b[k*16 +: 16]));
      if (s > 32767)       r[k*16 +: 16] = 16'h7FFF;
      else if (s < -32768) r[k*16 +: 16] = 16'h8000;
      else                 r[k*16 +: 16] = s[15:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_shuf(logic [63:0] b, logic [7:0] c);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) r[k*16 +: 16] = b[int'(c[k*2 +: 2])*16 +: 16];
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [1:0] o, logic [63:0] a, logic [63:0] b,
                     logic [7:0] c, logic [63:0] exp, string req);
    logic [63:0] held;
    @(negedge clk);
    op = o; src_a = a; src_b = b; imm = c; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    chk(req, result, exp);
    held = result;
    // Idle cycle with scrambled inputs: nothing may change (R2)
    in_valid = 1'b0; src_a = ~a; src_b = ~b; imm = ~c; op = ~o;
    @(negedge clk);
    chk("R2 idle", {63'd0, out_valid}, 64'd0);
    chk("R2 hold", result, held);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '1; src_b = '1; imm = '1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 result", result, 64'd0);
    rst_n = 1'b1;

    // Named corner cases
    run(2'd0, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0001_0001,
        8'h00, 64'h0000_FFFF_0000_0000, "R3 lane carry dropped");
    run(2'd1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001,
        8'h00, 64'h0000_0000_0001_0000, "R4 carry bit15 to bit16");
    run(2'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001,
        8'h00, 64'h0000_0000_0000_0000, "R4 no carry past bit31");
    run(2'd2, 64'h7FFF_7FFF_0100_7000, 64'h0001_7FFF_0200_1000,
        8'h00, 64'h7FFF_7FFF_0300_7FFF, "R6 positive clamp");
    run(2'd2, 64'h8000_8000_FF00_9000, 64'hFFFF_8000_FF00_E000,
        8'h00, 64'h8000_8000_FE00_8000, "R7 negative clamp");
    run(2'd2, 64'h7FFF_8000_0005_FFFF, 64'h8000_7FFF_FFFB_0001,
        8'h00, 64'hFFFF_FFFF_0000_0000, "R5 mixed signs in range");
    run(2'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'h4444_3333_2222_1111,
        8'h00, 64'h1111_1111_1111_1111, "R8 imm 0x00");
    run(2'd3, 64'h0123_4567_89AB_CDEF, 64'h4444_3333_2222_1111,
        8'hFF, 64'h4444_4444_4444_4444, "R8 imm 0xFF");
    run(2'd3, 64'h0, 64'h4444_3333_2222_1111,
        8'h1B, 64'h1111_2222_3333_4444, "R8 reverse");

    // Sweeps over boundary lane values
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [63:0] a, b;
        a = {VALS[i], VALS[j], VALS[(i+j)%8], VALS[7-i]};
        b = {VALS[j], VALS[(i*3+1)%8], VALS[i], VALS[(j+5)%8]};
        run(2'd0, a, b, 8'h00, exp_addw(a, b), "R3 sweep");
        run(2'd1, a, b, 8'h00, exp_addd(a, b), "R4 sweep");
        run(2'd2, a, b, 8'h00, exp_addsw(a, b), "R5/R6/R7 sweep");
      end
    end

    // All permute immediates, with src_a varying to show it is ignored
    for (int c = 0; c < 256; c++) begin
      logic [63:0] b;
      b = 64'hA0A1_B2B3_C4C5_D6D7 ^ {4{16'(c * 16'h0101)}};
      run(2'd3, {4{16'(c)}} ^ 64'h5A5A_0F0F_3C3C_9696, b, 8'(c),
          exp_shuf(b, 8'(c)), "R8 sweep");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule